// File: doc/BRIEF.md
# Breathing and Blinking LED Controller

This block drives a single LED pin. A small register file, written and read over a plain address/data port, selects one of four modes. Off holds the pin at its inactive level. Fixed-duty PWM uses 8-bit resolution. Blinking uses a prescaled tick, a period and an on-time. Breathing ramps the brightness up and down along a piecewise-linear curve. A polarity bit chooses whether the pin is active high or active low.

The whole block runs from one slow clock, intended to be the 32.768 kHz standby clock, so blinking and breathing continue while the rest of the system sleeps. An 8-bit counter sets a PWM period of 256 clocks. Register writes go into a staging bank at once. They reach the output logic only when the PWM counter wraps, so the pin never shows a partly updated setting.

Breathing splits each ramp into four segments. The segments are separated by three level thresholds. Each segment has its own step size and its own count of extra PWM periods to wait between steps. Rise and fall can be programmed independently (asymmetric), or the fall can reuse the rise table (symmetric). Programmable dwell times apply at full and at zero brightness.

Top module: `led_breath_ctrl`

## Requirements
- R1: After synchronous reset, `led_o` is 0, the block is in off mode, and every register reads back 0.
- R2: Control register address 0 holds mode in bits [1:0] and polarity in bit 2. Mode code 0 holds `led_o` at the polarity bit value.
- R3: In mode code 1, the PWM counter runs 0..255. The raw output is active while the counter is below the 8-bit duty held in register 1 bits [7:0]. Duty 0 is never active and duty 255 is active 255 clocks in 256.
- R4: `led_o` is the raw output XOR the polarity bit, so polarity 1 inverts every mode.
- R5: In mode code 2, a tick fires every prescale+1 clocks, with prescale in register 2. A phase counter steps through 0..period on each tick. The pin is active while phase < on-time. Register 3 holds on-time in bits [15:8] and period in bits [7:0].
- R6: In mode code 3, the level starts at 0 and rises. Once per PWM period the block checks the hold count of the current segment. After hold+1 periods the level advances by that segment's step. The segment index is the number of thresholds that are less than or equal to the level. The thresholds are register 4 bits [7:0], register 4 bits [15:8] and register 5 bits [7:0]. Rise segment k uses register 8+k, with the step in bits [7:0] and the hold in bits [15:8]. A step that reaches 255 or more sets the level to 255.
- R7: At level 255 the level stays for top-dwell+1 periods (register 5 bits [15:8]) before falling. At level 0 it stays for bottom-dwell+1 periods (register 6 bits [7:0]) before rising again. A fall step whose size is at least the level sets the level to 0.
- R8: With control bit 3 clear, the falling ramp uses fall segments from register 12+k. With the bit set, it uses the rise table.
- R9: Writes land in staging storage and are readable on `rd_data` one clock after `rd_addr` is presented. They take effect only on the clock where the PWM counter wraps from 255 to 0.
- R10: When a commit changes the mode, the breathing level returns to 0 and rising, and the blink prescaler and phase return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Standby clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Staged register value, registered |
| led_o | output | 1 | LED pin drive |

## Verification
The bench targets writes that arrive in the middle of a PWM period. A design that applied them at once would change the duty or the mode partway through a period, and the clock-by-clock comparison would show a wrong pin level before the wrap. Segment boundaries and saturation at 255 and at 0 are driven with steps that overshoot. A design that wrapped the level, or picked the segment off by one at a threshold, would produce a brightness sequence that diverges within a few periods. Switching the symmetric bit while breathing, and leaving and re-entering breathing, expose a design that reads the wrong fall table or resumes from a stale level or blink phase.

// File: rtl/led_pkg.sv
package led_pkg;
  localparam int LVL_W = 8;
  localparam int DW    = 2 * LVL_W;
  localparam int AW    = 4;
  localparam int NREG  = 1 << AW;
  localparam int NSEG  = 4;
  localparam int NTH   = NSEG - 1;

  localparam int A_CTRL  = 0;
  localparam int A_DUTY  = 1;
  localparam int A_PRE   = 2;
  localparam int A_BLINK = 3;
  localparam int A_THA   = 4;
  localparam int A_THB   = 5;
  localparam int A_BOT   = 6;
  localparam int A_RISE  = 8;
  localparam int A_FALL  = 12;

  typedef enum logic [1:0] {M_OFF, M_PWM, M_BLINK, M_BREATHE} mode_e;
  typedef enum logic [1:0] {B_RISE, B_TOP, B_FALL, B_BOT} bst_e;

  typedef struct packed {
    mode_e                       mode;
    logic                        pol;
    logic                        sym;
    logic [LVL_W-1:0]            duty;
    logic [DW-1:0]               pre;
    logic [LVL_W-1:0]            bper;
    logic [LVL_W-1:0]            bon;
    logic [NTH-1:0][LVL_W-1:0]   th;
    logic [LVL_W-1:0]            htop;
    logic [LVL_W-1:0]            hbot;
    logic [NSEG-1:0][LVL_W-1:0]  rstep;
    logic [NSEG-1:0][LVL_W-1:0]  rhold;
    logic [NSEG-1:0][LVL_W-1:0]  fstep;
    logic [NSEG-1:0][LVL_W-1:0]  fhold;
  } cfg_t;
endpackage

// File: rtl/led_regs.sv
module led_regs
  import led_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  input  logic          commit,
  output logic [DW-1:0] rd_data,
  output logic [1:0]    stg_mode,
  output cfg_t          cfg
);
  logic [NREG-1:0][DW-1:0] stg;

  assign stg_mode = stg[A_CTRL][1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      stg     <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en) stg[wr_addr] <= wr_data;
      rd_data <= stg[rd_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (commit) begin
      cfg.mode  <= mode_e'(stg[A_CTRL][1:0]);
      cfg.pol   <= stg[A_CTRL][2];
      cfg.sym   <= stg[A_CTRL][3];
      cfg.duty  <= stg[A_DUTY][LVL_W-1:0];
      cfg.pre   <= stg[A_PRE];
      cfg.bper  <= stg[A_BLINK][LVL_W-1:0];
      cfg.bon   <= stg[A_BLINK][DW-1:LVL_W];
      cfg.th[0] <= stg[A_THA][LVL_W-1:0];
      cfg.th[1] <= stg[A_THA][DW-1:LVL_W];
      cfg.th[2] <= stg[A_THB][LVL_W-1:0];
      cfg.htop  <= stg[A_THB][DW-1:LVL_W];
      cfg.hbot  <= stg[A_BOT][LVL_W-1:0];
      for (int k = 0; k < NSEG; k++) begin
        cfg.rstep[k] <= stg[A_RISE+k][LVL_W-1:0];
        cfg.rhold[k] <= stg[A_RISE+k][DW-1:LVL_W];
        cfg.fstep[k] <= stg[A_FALL+k][LVL_W-1:0];
        cfg.fhold[k] <= stg[A_FALL+k][DW-1:LVL_W];
      end
    end
  end
endmodule

// File: rtl/led_blink.sv
module led_blink
  import led_pkg::*;
#(
  parameter int PW = DW,
  parameter int W  = LVL_W
)(
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          clr,
  input  logic [PW-1:0] prescale,
  input  logic [W-1:0]  period,
  input  logic [W-1:0]  on_time,
  output logic          on_o
);
  logic [PW-1:0] pre_q;
  logic [W-1:0]  ph_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre_q <= '0;
      ph_q  <= '0;
    end else if (en) begin
      if (pre_q >= prescale) begin
        pre_q <= '0;
        ph_q  <= (ph_q >= period) ? '0 : ph_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign on_o = ph_q < on_time;
endmodule

// File: rtl/led_breathe.sv
module led_breathe
  import led_pkg::*;
#(
  parameter int W  = LVL_W,
  parameter int NS = NSEG
)(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step,
  input  logic                 clr,
  input  logic                 sym,
  input  logic [NS-2:0][W-1:0] th,
  input  logic [W-1:0]         htop,
  input  logic [W-1:0]         hbot,
  input  logic [NS-1:0][W-1:0] rstep,
  input  logic [NS-1:0][W-1:0] rhold,
  input  logic [NS-1:0][W-1:0] fstep,
  input  logic [NS-1:0][W-1:0] fhold,
  output logic [W-1:0]         lvl,
  output bst_e                 st
);
  localparam int SW = $clog2(NS);

  logic [NS-2:0] ge;
  logic [SW-1:0] seg;
  logic [W-1:0]  cur_step, cur_hold, wt;
  logic [W:0]    sum;
  logic          use_fall;

  for (genvar g = 0; g < NS - 1; g++) begin : g_thr
    assign ge[g] = lvl >= th[g];
  end

  always_comb begin
    seg = '0;
    for (int i = 0; i < NS - 1; i++)
      if (ge[i]) seg = seg + 1'b1;
  end

  assign use_fall = (st == B_FALL) && !sym;
  assign cur_step = use_fall ? fstep[seg] : rstep[seg];
  assign cur_hold = use_fall ? fhold[seg] : rhold[seg];
  assign sum      = {1'b0, lvl} + {1'b0, cur_step};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      lvl <= '0;
      st  <= B_RISE;
      wt  <= '0;
    end else if (step) begin
      unique case (st)
        B_RISE: begin
          if (wt < cur_hold) wt <= wt + 1'b1;
          else begin
            wt <= '0;
            if (sum[W] || (&sum[W-1:0])) begin
              lvl <= '1;
              st  <= B_TOP;
            end else begin
              lvl <= sum[W-1:0];
            end
          end
        end
        B_TOP: begin
          if (wt < htop) wt <= wt + 1'b1;
          else begin
            wt <= '0;
            st <= B_FALL;
          end
        end
        B_FALL: begin
          if (wt < cur_hold) wt <= wt + 1'b1;
          else begin
            wt <= '0;
            if (lvl <= cur_step) begin
              lvl <= '0;
              st  <= B_BOT;
            end else begin
              lvl <= lvl - cur_step;
            end
          end
        end
        default: begin
          if (wt < hbot) wt <= wt + 1'b1;
          else begin
            wt <= '0;
            st <= B_RISE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/led_breath_ctrl.sv
module led_breath_ctrl
  import led_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          led_o
);
  cfg_t             cfg;
  logic [1:0]       stg_mode;
  logic [LVL_W-1:0] cnt;
  logic             bnd, mode_chg, blink_on, raw;
  logic [LVL_W-1:0] lvl;
  bst_e             bst;
  logic [1:0]       mode_a;
  logic             pol_a;

  assign bnd      = &cnt;
  assign mode_chg = bnd && (stg_mode != cfg.mode);
  assign mode_a   = cfg.mode;
  assign pol_a    = cfg.pol;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  led_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .commit(bnd), .rd_data(rd_data), .stg_mode(stg_mode),
    .cfg(cfg)
  );

  led_blink u_blink (
    .clk(clk), .rst(rst), .en(cfg.mode == M_BLINK), .clr(mode_chg),
    .prescale(cfg.pre), .period(cfg.bper), .on_time(cfg.bon), .on_o(blink_on)
  );

  led_breathe u_breathe (
    .clk(clk), .rst(rst), .step(bnd && (cfg.mode == M_BREATHE) && !mode_chg),
    .clr(mode_chg), .sym(cfg.sym), .th(cfg.th), .htop(cfg.htop), .hbot(cfg.hbot),
    .rstep(cfg.rstep), .rhold(cfg.rhold), .fstep(cfg.fstep), .fhold(cfg.fhold),
    .lvl(lvl), .st(bst)
  );

  always_comb begin
    unique case (cfg.mode)
      M_OFF:   raw = 1'b0;
      M_PWM:   raw = cnt < cfg.duty;
      M_BLINK: raw = blink_on;
      default: raw = cnt < lvl;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) led_o <= 1'b0;
    else     led_o <= raw ^ cfg.pol;
  end
endmodule

// File: rtl/led_breath_ctrl_chk.sv
module led_breath_ctrl_chk #(
  parameter int W = 8
)(
  input logic         clk,
  input logic         rst,
  input logic         led_o,
  input logic [1:0]   mode_a,
  input logic         pol_a,
  input logic         bnd,
  input logic [W-1:0] lvl,
  input logic [1:0]   bst
);
  // R2: off mode drives the inactive level
  a_r2_off_level: assert property (@(posedge clk) disable iff (rst)
    (mode_a == 2'd0) |=> (led_o == $past(pol_a)));

  // R9: mode and polarity change only after a counter wrap
  a_r9_mode_commit: assert property (@(posedge clk) disable iff (rst)
    !$past(bnd) |-> $stable(mode_a));
  a_r9_pol_commit: assert property (@(posedge clk) disable iff (rst)
    !$past(bnd) |-> $stable(pol_a));

  // R6: breathing level moves only at period boundaries and never falls while rising
  a_r6_level_timing: assert property (@(posedge clk) disable iff (rst)
    !$past(bnd) |-> $stable(lvl));
  a_r6_rise_mono: assert property (@(posedge clk) disable iff (rst)
    (bst == 2'd0 && $past(bst) == 2'd0 && mode_a == 2'd3 && $past(mode_a) == 2'd3)
      |-> (lvl >= $past(lvl)));

  // R7: dwell states sit at the extremes
  a_r7_top_full: assert property (@(posedge clk) disable iff (rst)
    (bst == 2'd1) |-> (&lvl));
  a_r7_bot_zero: assert property (@(posedge clk) disable iff (rst)
    (bst == 2'd3) |-> (lvl == '0));
endmodule

bind led_breath_ctrl led_breath_ctrl_chk #(.W(led_pkg::LVL_W)) u_chk (
  .clk(clk), .rst(rst), .led_o(led_o), .mode_a(mode_a), .pol_a(pol_a),
  .bnd(bnd), .lvl(lvl), .bst(bst)
);

// File: tb/sim_led_breath_ctrl.sv
`timescale 1ns/1ps
module sim_led_breath_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        led_o;

  int nchk = 0, nerr = 0, cyc = 0;
  bit done = 0;
  string cur = "R1";

  led_breath_ctrl u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .led_o(led_o)
  );

  always #2.5 clk = ~clk;

  // behavioural reference
  int sreg [16];
  int areg [16];
  int m_cnt, m_pre, m_ph, m_lvl, m_st, m_wt, m_led;
  int md, pl, raw, nm;

  task automatic breathe_step();
    int seg, stp, hld, th0, th1, th2, sym, idx;
    th0 = areg[4] & 255; th1 = (areg[4] >> 8) & 255; th2 = areg[5] & 255;
    sym = (areg[0] >> 3) & 1;
    seg = (m_lvl >= th0) + (m_lvl >= th1) + (m_lvl >= th2);
    idx = (m_st == 2 && sym == 0) ? 12 + seg : 8 + seg;
    stp = areg[idx] & 255; hld = (areg[idx] >> 8) & 255;
    case (m_st)
      0: if (m_wt < hld) m_wt++;
         else begin
           m_wt = 0;
           if (m_lvl + stp >= 255) begin m_lvl = 255; m_st = 1; end
           else m_lvl = m_lvl + stp;
         end
      1: if (m_wt < ((areg[5] >> 8) & 255)) m_wt++; else begin m_wt = 0; m_st = 2; end
      2: if (m_wt < hld) m_wt++;
         else begin
           m_wt = 0;
           if (m_lvl <= stp) begin m_lvl = 0; m_st = 3; end
           else m_lvl = m_lvl - stp;
         end
      default: if (m_wt < (areg[6] & 255)) m_wt++; else begin m_wt = 0; m_st = 0; end
    endcase
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      for (int i = 0; i < 16; i++) begin sreg[i] = 0; areg[i] = 0; end
      m_cnt = 0; m_pre = 0; m_ph = 0; m_lvl = 0; m_st = 0; m_wt = 0; m_led = 0;
    end else begin
      md = areg[0] & 3; pl = (areg[0] >> 2) & 1;
      case (md)
        0: raw = 0;
        1: raw = (m_cnt < (areg[1] & 255)) ? 1 : 0;
        2: raw = (m_ph < ((areg[3] >> 8) & 255)) ? 1 : 0;
        default: raw = (m_cnt < m_lvl) ? 1 : 0;
      endcase
      m_led = raw ^ pl;
      if (md == 2) begin
        if (m_pre >= areg[2]) begin
          m_pre = 0;
          m_ph = (m_ph >= (areg[3] & 255)) ? 0 : m_ph + 1;
        end else m_pre++;
      end
      if (m_cnt == 255) begin
        nm = sreg[0] & 3;
        if (nm != md) begin
          m_lvl = 0; m_st = 0; m_wt = 0; m_pre = 0; m_ph = 0;
        end else if (md == 3) breathe_step();
        for (int i = 0; i < 16; i++) areg[i] = sreg[i];
      end
      if (wr_en) sreg[wr_addr] = int'(wr_data);
      m_cnt = (m_cnt + 1) % 256;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // every-clock comparison against the reference
  always @(negedge clk) begin
    if (!rst && !done) chk(led_o == m_led[0], cur, int'(led_o), m_led);
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[3:0]; wr_data = d[15:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input int e, input string req);
    @(negedge clk);
    rd_addr = a[3:0];
    @(negedge clk);
    chk(rd_data == e[15:0], req, int'(rd_data), e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_on(input int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk);
      if (led_o) c++;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc >= 190000 && !done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      finish_run();
    end
  end

  initial begin
    int c;
    repeat (4) @(negedge clk);
    chk(led_o == 1'b0, "R1 led in reset", int'(led_o), 0);
    rst = 1'b0;
    rd(0, 0, "R1 ctrl reads zero");
    rd(3, 0, "R1 blink reads zero");
    rd(15, 0, "R1 fall seg reads zero");

    cur = "R2 off level";
    wr(0, 16'h0004);
    idle(600);
    chk(led_o == 1'b1, "R2 off with polarity", int'(led_o), 1);

    cur = "R3 pwm";
    wr(1, 16'h0040); wr(0, 16'h0001);
    idle(600); count_on(256, c);
    chk(c == 64, "R3 duty 64", c, 64);
    wr(1, 0); idle(600); count_on(256, c);
    chk(c == 0, "R3 duty 0", c, 0);
    wr(1, 255); idle(600); count_on(256, c);
    chk(c == 255, "R3 duty 255", c, 255);

    cur = "R4 polarity";
    wr(1, 16'h0030); wr(0, 16'h0005);
    idle(600); count_on(256, c);
    chk(c == 208, "R4 inverted duty", c, 208);

    cur = "R9 mid-period write";
    idle(100); wr(1, 16'h0080); idle(77); wr(0, 16'h0001);
    rd(1, 16'h0080, "R9 readback duty");
    idle(600); count_on(256, c);
    chk(c == 128, "R9 committed duty", c, 128);

    cur = "R5 blink";
    wr(2, 3); wr(3, 16'h0409); wr(0, 16'h0002);
    idle(600); count_on(40, c);
    chk(c == 16, "R5 blink on clocks", c, 16);
    wr(2, 0); wr(3, 16'h0302);
    idle(600); count_on(40, c);
    chk(c == 40, "R5 on-time past period", c, 40);

    cur = "R6 R7 breathe asymmetric";
    wr(4, 16'h8040); wr(5, 16'h03C0); wr(6, 16'h0001);
    wr(8, 16'h0010); wr(9, 16'h0108); wr(10, 16'h0020); wr(11, 16'h0240);
    wr(12, 16'h0020); wr(13, 16'h0010); wr(14, 16'h0008); wr(15, 16'h0004);
    wr(0, 16'h0003);
    rd(11, 16'h0240, "R6 rise seg readback");
    idle(35000);

    cur = "R8 breathe symmetric";
    wr(0, 16'h000B);
    idle(30000);

    cur = "R10 mode restart";
    wr(0, 16'h0001); idle(600);
    wr(0, 16'h0003); idle(9000);
    wr(0, 16'h0002); idle(300);
    wr(0, 16'h0003); idle(3000);

    finish_run();
  end
endmodule